// File: doc/BRIEF.md
# DMA Request Pin Sampling Controller

This block watches the active-low external DMA request pin of one channel and decides, from the channel's mode bits and the current bus activity, when that pin is sampled and when a transfer request is raised towards the bus arbiter. It does not move data, count bytes or form addresses. Its only job is to turn the pin and the bus status into a clean internal request at the sample points the mode calls for.

Three static configuration bits pick the behaviour. One picks cycle-steal or burst operation. One picks falling-edge or low-level detection. One picks single or dual address transfers. The bus reports its state within a four-state cycle (T1 to T4), whether the DMA channel owns the cycle, whether the cycle is a write, and a strobe on its last state. A transfer-end input sets a sticky end flag, and software drops that flag with a one-cycle clear strobe. While the flag is up, no request is raised.

The pin passes through a synchronizer of `SYNC_STAGES` flops, two by default. All timing below is counted from the synchronized level. The block has no data stream, so every pin is a plain level or strobe, and there is no back-pressure path.

Top module: `dreq_sampler`

## Requirements
- R1: With `SYNC_STAGES` = 2, a pin change that falls on a sample point reaches `xfer_req` at the third rising clock edge after the pin changes: two synchronizer flops, then the request register.
- R2: In cycle-steal level mode, once a low has been seen, the synchronized pin is sampled only in state T2 (`bus_state` = 1) of cycles the DMA owns. A withdrawal that reaches the sampler after T2 therefore leaves `xfer_req` high until the next DMA-owned T2.
- R3: In cycle-steal edge mode, a falling edge of the synchronized pin sets `xfer_req`. The request stays set until a DMA transfer completes: a DMA-owned cycle-end in single address mode, or a DMA-owned write cycle-end in dual address mode. If a new fall and a completion come in the same cycle, the fall wins.
- R4: In burst edge mode, a falling edge starts a burst. `xfer_req` then stays high, and the pin has no effect, until `xfer_end`.
- R5: In burst level mode with single addressing, once a low has been seen, the pin is sampled only on `bus_cyc_end`, whoever owns the cycle.
- R6: In burst level mode with dual addressing, once a low has been seen, the pin is sampled only in T1 (`bus_state` = 0) of DMA-owned read cycles.
- R7: In any level mode, a sample point that finds the pin high clears `xfer_req` and returns the sampler to sampling every clock until a low is seen.
- R8: `xfer_end` sets `te_flag` and clears `xfer_req` at the same edge. If `xfer_end` and `te_clear` arrive together, `xfer_end` wins.
- R9: `te_clear` while `te_flag` is set clears the flag at the next edge.
- R10: While `te_flag` is set, no request is raised and `xfer_req` stays low, but the edge history keeps following the pin every clock. A fall that happens while the flag is set is therefore never acted on after the clear; a new fall is needed.
- R11: After reset, `xfer_req` and `te_flag` are low, and the synchronizer and edge history hold the idle (high) level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dreq_n | input | 1 | External DMA request pin, active low, asynchronous |
| cfg_burst | input | 1 | 1 = burst, 0 = cycle-steal |
| cfg_level | input | 1 | 1 = low-level detection, 0 = falling-edge detection |
| cfg_dual | input | 1 | 1 = dual address, 0 = single address |
| bus_state | input | 2 | Current bus state, 0..3 = T1..T4 |
| bus_dma_own | input | 1 | Current bus cycle belongs to the DMA channel |
| bus_write | input | 1 | Current bus cycle is a write |
| bus_cyc_end | input | 1 | Last state of the current bus cycle |
| xfer_end | input | 1 | Transfer-end condition reached |
| te_clear | input | 1 | One-cycle software clear of the end flag |
| xfer_req | output | 1 | Pending transfer request to the arbiter |
| te_flag | output | 1 | Sticky transfer-end flag |

## Verification
Every clock, the assertions check the invariants that need no scenario. No request appears while the end flag is up. The end flag sets on `xfer_end` and drops on a clear. A running edge burst keeps its request. A tracking level sampler keeps its request steady between sample points. A cycle-steal edge request only rises after a detected fall. What only the bench's scenarios can show is the exact sample timing: the extra transfer when the pin is withdrawn late in a DMA cycle, the different sample points of single and dual burst, the return to every-clock sampling after a miss, and falls swallowed while the flag was up. A behavioural model compared on every clock covers these.

// File: rtl/dreq_pkg.sv
package dreq_pkg;
  typedef enum logic [1:0] {
    ST_T1 = 2'd0,
    ST_T2 = 2'd1,
    ST_T3 = 2'd2,
    ST_T4 = 2'd3
  } bus_state_e;

  typedef struct packed {
    logic burst;
    logic level;
    logic dual;
  } dreq_cfg_t;

  typedef enum logic [1:0] {
    MODE_CS_EDGE    = 2'd0,
    MODE_CS_LEVEL   = 2'd1,
    MODE_BURST_EDGE = 2'd2,
    MODE_BURST_LVL  = 2'd3
  } dreq_mode_e;

  function automatic dreq_mode_e mode_of(dreq_cfg_t c);
    return dreq_mode_e'({c.burst, c.level});
  endfunction
endpackage

// File: rtl/dreq_sync.sv
module dreq_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  input  logic hold,
  output logic lvl_n,
  output logic fall
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] chain;
  logic          last_n;

  generate
    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= 1'b1;
          else        chain[0] <= pin_n;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[i] <= 1'b1;
          else        chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign lvl_n = chain[LAST];

  // Edge history follows the synchronized level unless a burst freezes it.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     last_n <= 1'b1;
    else if (!hold) last_n <= lvl_n;
  end

  assign fall = last_n & ~lvl_n;

  // R4: a burst in progress keeps the history it had when it started.
  p_hold_freezes_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(hold) |-> $stable(last_n));
endmodule

// File: rtl/dreq_point.sv
module dreq_point
  import dreq_pkg::*;
(
  input  dreq_cfg_t  cfg,
  input  logic [1:0] bus_state,
  input  logic       bus_dma_own,
  input  logic       bus_write,
  input  logic       bus_cyc_end,
  output logic       track_pt,
  output logic       xfer_done
);
  bus_state_e st;
  assign st = bus_state_e'(bus_state);

  always_comb begin
    unique case (mode_of(cfg))
      MODE_CS_LEVEL:  track_pt = bus_dma_own && (st == ST_T2);
      MODE_BURST_LVL: track_pt = cfg.dual ? (bus_dma_own && !bus_write && (st == ST_T1))
                                          : bus_cyc_end;
      default:        track_pt = 1'b1;
    endcase
  end

  // A DMA transfer is complete at the end of its last DMA-owned cycle.
  assign xfer_done = bus_dma_own && bus_cyc_end && (!cfg.dual || bus_write);
endmodule

// File: rtl/dreq_te.sv
module dreq_te (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic te
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   te <= 1'b0;
    else if (set) te <= 1'b1;
    else if (clr) te <= 1'b0;
  end

  p_end_sets_te_r8: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> te);
  p_clear_drops_te_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (te && clr && !set) |=> !te);
endmodule

// File: rtl/dreq_sampler.sv
module dreq_sampler
  import dreq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       dreq_n,
  input  logic       cfg_burst,
  input  logic       cfg_level,
  input  logic       cfg_dual,
  input  logic [1:0] bus_state,
  input  logic       bus_dma_own,
  input  logic       bus_write,
  input  logic       bus_cyc_end,
  input  logic       xfer_end,
  input  logic       te_clear,
  output logic       xfer_req,
  output logic       te_flag
);
  dreq_cfg_t  cfg;
  dreq_mode_e mode;
  logic lvl_n, fall, track_pt, xfer_done;
  logic pend_q, run_q, track_q;
  logic samp;

  assign cfg  = '{burst: cfg_burst, level: cfg_level, dual: cfg_dual};
  assign mode = mode_of(cfg);

  dreq_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_n(dreq_n), .hold(run_q),
    .lvl_n(lvl_n), .fall(fall));

  dreq_point u_point (
    .cfg(cfg), .bus_state(bus_state), .bus_dma_own(bus_dma_own),
    .bus_write(bus_write), .bus_cyc_end(bus_cyc_end),
    .track_pt(track_pt), .xfer_done(xfer_done));

  dreq_te u_te (
    .clk(clk), .rst_n(rst_n), .set(xfer_end), .clr(te_clear), .te(te_flag));

  // Level modes sample every clock until a low is seen, then only at track points.
  assign samp = track_q ? track_pt : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      run_q   <= 1'b0;
      track_q <= 1'b0;
    end else if (xfer_end) begin
      pend_q  <= 1'b0;
      run_q   <= 1'b0;
      track_q <= 1'b0;
    end else if (!te_flag) begin
      unique case (mode)
        MODE_CS_LEVEL, MODE_BURST_LVL: begin
          if (samp) begin
            pend_q  <= ~lvl_n;
            track_q <= ~lvl_n;
          end
        end
        MODE_BURST_EDGE: begin
          if (!run_q && fall) begin
            run_q  <= 1'b1;
            pend_q <= 1'b1;
          end
        end
        default: begin
          if (fall)           pend_q <= 1'b1;
          else if (xfer_done) pend_q <= 1'b0;
        end
      endcase
    end
  end

  assign xfer_req = pend_q;

  p_te_blocks_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
    te_flag |-> !xfer_req);
  p_burst_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !xfer_end) |=> xfer_req);
  p_track_steady_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_level && track_q && !track_pt && !xfer_end && !te_flag) |=> $stable(xfer_req));
  p_edge_needs_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_level && !cfg_burst && !xfer_req && !(fall && !te_flag)) |=> !xfer_req);
endmodule

// File: tb/dreq_sampler_tb.sv
module dreq_sampler_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dreq_n = 1'b1;
  logic cfg_burst = 1'b0, cfg_level = 1'b0, cfg_dual = 1'b0;
  logic [1:0] bus_state = 2'd0;
  logic bus_dma_own = 1'b0, bus_write = 1'b0, bus_cyc_end = 1'b0;
  logic xfer_end = 1'b0, te_clear = 1'b0;
  logic xfer_req, te_flag;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  string cur_req = "R11";

  always #2.5 clk = ~clk;

  dreq_sampler u_dut (
    .clk(clk), .rst_n(rst_n), .dreq_n(dreq_n),
    .cfg_burst(cfg_burst), .cfg_level(cfg_level), .cfg_dual(cfg_dual),
    .bus_state(bus_state), .bus_dma_own(bus_dma_own), .bus_write(bus_write),
    .bus_cyc_end(bus_cyc_end), .xfer_end(xfer_end), .te_clear(te_clear),
    .xfer_req(xfer_req), .te_flag(te_flag));

  // Behavioural reference: pin history queue, request, burst, tracking, end flag.
  bit pin_q[$];
  bit m_prev = 1, m_req = 0, m_burst = 0, m_track = 0, m_te = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q = '{1'b1, 1'b1};
      m_prev = 1; m_req = 0; m_burst = 0; m_track = 0; m_te = 0;
    end else begin
      bit seen_low, edge_now, point, finished, nreq, nburst, ntrack, nte;
      seen_low = !pin_q[0];
      edge_now = m_prev && seen_low;
      if (!cfg_burst) point = bus_dma_own && bus_state == 2'd1;
      else if (cfg_dual) point = bus_dma_own && !bus_write && bus_state == 2'd0;
      else point = bus_cyc_end;
      finished = bus_dma_own && bus_cyc_end && (!cfg_dual || bus_write);
      nreq = m_req; nburst = m_burst; ntrack = m_track; nte = m_te;
      if (!m_burst) m_prev = pin_q[0];
      if (xfer_end) begin
        nte = 1; nreq = 0; nburst = 0; ntrack = 0;
      end else begin
        if (te_clear) nte = 0;
        if (!m_te) begin
          if (cfg_level) begin
            if (!m_track || point) begin nreq = seen_low; ntrack = seen_low; end
          end else if (cfg_burst) begin
            if (!m_burst && edge_now) begin nburst = 1; nreq = 1; end
          end else begin
            if (edge_now) nreq = 1;
            else if (finished) nreq = 0;
          end
        end
      end
      m_req = nreq; m_burst = nburst; m_track = ntrack; m_te = nte;
      void'(pin_q.pop_front());
      pin_q.push_back(dreq_n);
    end
  end

  task automatic check(string tag, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    check(cur_req, "xfer_req", xfer_req, m_req);
    check(cur_req, "te_flag", te_flag, m_te);
  end

  task automatic step(bit pin, bit own, bit wr, int st, bit ce, bit xe = 0, bit tc = 0);
    dreq_n = pin; bus_dma_own = own; bus_write = wr; bus_state = 2'(st);
    bus_cyc_end = ce; xfer_end = xe; te_clear = tc;
    @(negedge clk);
  endtask

  task automatic idle(bit pin, int n);
    for (int i = 0; i < n; i++) step(pin, 0, 0, 0, 0);
  endtask

  // One four-state bus cycle; pins[k] is the pin level during state k.
  task automatic cyc(bit own, bit wr, bit [3:0] pins);
    for (int s = 0; s < 4; s++) step(pins[s], own, wr, s, s == 3);
  endtask

  task automatic restart(bit b, bit l, bit d);
    rst_n = 0; dreq_n = 1; xfer_end = 0; te_clear = 0; bus_cyc_end = 0; bus_dma_own = 0;
    cfg_burst = b; cfg_level = l; cfg_dual = d;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  initial begin
    restart(0, 1, 0);
    cur_req = "R11";
    check("R11", "reset xfer_req", xfer_req, 1'b0);
    check("R11", "reset te_flag", te_flag, 1'b0);

    // R1: direct latency count, cycle-steal level, untracked.
    cur_req = "R1";
    idle(1, 3);
    step(0, 0, 0, 0, 0);
    check("R1", "after 1 edge", xfer_req, 1'b0);
    step(0, 0, 0, 0, 0);
    check("R1", "after 2 edges", xfer_req, 1'b0);
    step(0, 0, 0, 0, 0);
    check("R1", "after 3 edges", xfer_req, 1'b1);

    // R2: tracked sampling at DMA T2; late withdrawal gives one more transfer.
    cur_req = "R2";
    cyc(1, 0, 4'b0000);
    cyc(0, 0, 4'b0000);
    cyc(1, 0, 4'b1000);
    step(1, 0, 0, 0, 0);
    check("R2", "held after late withdrawal", xfer_req, 1'b1);
    idle(1, 4);
    check("R2", "held with no DMA T2", xfer_req, 1'b1);
    cyc(1, 0, 4'b1111);
    check("R2", "dropped at next DMA T2", xfer_req, 1'b0);
    // R7: fall back to every-clock sampling.
    cur_req = "R7";
    idle(0, 3);
    check("R7", "resampled without bus cycle", xfer_req, 1'b1);
    cyc(0, 0, 4'b1111);
    cyc(1, 1, 4'b0000);

    // R3: cycle-steal edge, single then dual.
    restart(0, 0, 0);
    cur_req = "R3";
    idle(1, 3); idle(0, 4);
    check("R3", "edge request", xfer_req, 1'b1);
    cyc(0, 0, 4'b0000);
    check("R3", "cpu cycle keeps request", xfer_req, 1'b1);
    cyc(1, 0, 4'b0000);
    check("R3", "single done clears", xfer_req, 1'b0);
    restart(0, 0, 1);
    idle(1, 3); idle(0, 4);
    cyc(1, 0, 4'b0000);
    check("R3", "dual read keeps request", xfer_req, 1'b1);
    cyc(1, 1, 4'b1111);
    check("R3", "dual write clears", xfer_req, 1'b0);
    idle(0, 4);

    // R4, R8, R9, R10: burst edge.
    restart(1, 0, 0);
    cur_req = "R4";
    idle(1, 3); idle(0, 3);
    for (int k = 0; k < 6; k++) cyc(1, 0, 4'(k % 2 ? 4'b0101 : 4'b1111));
    check("R4", "burst ignores pin", xfer_req, 1'b1);
    cur_req = "R8";
    step(1, 1, 0, 3, 1, 1, 1);
    check("R8", "end sets flag over clear", te_flag, 1'b1);
    check("R8", "end clears request", xfer_req, 1'b0);
    cur_req = "R10";
    idle(1, 3); idle(0, 4);
    check("R10", "no request while flag", xfer_req, 1'b0);
    cur_req = "R9";
    step(0, 0, 0, 0, 0, 0, 1);
    check("R9", "flag cleared", te_flag, 1'b0);
    cur_req = "R10";
    idle(0, 5);
    check("R10", "old fall not acted on", xfer_req, 1'b0);
    idle(1, 3); idle(0, 4);
    check("R10", "new fall after clear", xfer_req, 1'b1);
    step(0, 0, 0, 0, 0, 1, 0);

    // R5: burst level single, sampling on any cycle end.
    restart(1, 1, 0);
    cur_req = "R5";
    idle(0, 4);
    cyc(0, 0, 4'b1110);
    cyc(0, 0, 4'b0111);
    check("R5", "sampled at cpu cycle end", xfer_req, 1'b0);
    idle(0, 4);
    cyc(1, 0, 4'b1100);
    idle(1, 3);
    check("R5", "no cycle end keeps request", xfer_req, 1'b1);
    cyc(0, 0, 4'b1111);
    check("R5", "dropped at cycle end", xfer_req, 1'b0);

    // R6: burst level dual, sampling at DMA read T1.
    restart(1, 1, 1);
    cur_req = "R6";
    idle(0, 4);
    cyc(1, 0, 4'b0000);
    cyc(1, 1, 4'b1111);
    cyc(0, 0, 4'b1111);
    check("R6", "write and cpu cycles do not sample", xfer_req, 1'b1);
    cyc(1, 0, 4'b1111);
    check("R6", "dropped at read T1", xfer_req, 1'b0);
    cur_req = "R7";
    idle(0, 4);
    check("R7", "every-clock after miss", xfer_req, 1'b1);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule